// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one PCI function. A host reaches it through a plain register port: an enable, a write flag, a byte offset, an access size of 1, 2 or 4 bytes and 32 bits of write data. Read data and an error flag come back in the same cycle as the access. Write data takes effect at the next rising clock edge.

The identity fields are fixed by parameters and cannot be written. These are the vendor and device codes, revision, class triple, header type, interrupt pin, subsystem codes and the two bus-timing hints. Only a few control fields are writable: command, status, cache line size with the latency timer, interrupt line, the six base address registers and the expansion ROM base. Each write is legal only for a specific pairing of offset and size.

The base address registers support the size-probe handshake. Writing all ones to a register makes it read back a mask that shows its window size, and its type bits are kept. A window size of zero marks an unused register, which always reads zero. Illegal accesses are rejected with a one-cycle error pulse and change nothing.

Top module: `cfg_header_regs`

## Requirements
- R1: A read with size 1, 2 or 4 returns the stored bytes starting at the offset, little-endian, with the lowest byte in bits 7:0. Bytes past the size or past offset 63 read as zero. Fields: vendor 0x00, device 0x02, command 0x04, status 0x06, revision 0x08, programming interface 0x09, subclass 0x0A, class 0x0B, cache line 0x0C, latency timer 0x0D, header type 0x0E, bases 0x10–0x27, subsystem vendor 0x2C, subsystem 0x2E, ROM base 0x30, interrupt line 0x3C, interrupt pin 0x3D, minimum grant 0x3E, maximum latency 0x3F. All other bytes are zero.
- R2: A read of size 0, 3, 5, 6 or 7 raises the error flag and returns zero data.
- R3: A 1-byte write is accepted only at offsets 0x0C and 0x3C. At any other offset it raises the error flag and the stored contents stay unchanged.
- R4: A 2-byte write is accepted only at offsets 0x04, 0x06 and 0x0C. A write at 0x0C loads the cache line size and the latency timer. Any other offset raises the error flag and nothing changes.
- R5: A write of size 0, 3, 5, 6 or 7 raises the error flag and changes nothing.
- R6: A 4-byte write is accepted only at the word offsets 0x10 to 0x24, at 0x30 and at 0x04. At 0x04 only bits 15:0 go into the command field, and status is left as it was. Other offsets raise the error flag.
- R7: Writing 0xFFFFFFFF to an implemented base register makes it read the inverse of (size − 1), with the register's read-only low bits kept.
- R8: A base register whose bit 0 is 1 keeps bits 1:0. Otherwise it keeps bits 3:0. An ordinary write stores the data with those bits replaced by their current values.
- R9: Writing 0xFFFFFFFE to the ROM base stores 0xFFFFFFFF. Any other value is stored as written.
- R10: A base register with size parameter 0 reads zero at all times. Writes to it are accepted without error and have no effect.
- R11: The error flag is high only in a cycle where the port is enabled and the access is illegal. A rejected access modifies no configuration byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 6 | Byte offset into the header |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data, little-endian |
| acc_rdata | output | 32 | Read data for the current access |
| acc_err | output | 1 | Rejected-access pulse |

## Verification
The bench builds the block with one base register of each kind. There is a 4 KiB memory register with its prefetch bit set, a 1 MiB memory register with clear type bits, a 16-byte memory register with type bits 2:1 set, two I/O registers of 256 and 4 bytes, and one unused slot. This lets the size probe hit both read-only masks, the smallest legal window of each type and the unused case. The identity parameters are distinct non-zero byte patterns, so a read from the wrong byte lane or the wrong offset shows up in the data. Reads that run past offset 63 are also covered.

// File: rtl/cfg_pkg.sv
// Shared constants and types for the configuration header register file.
// Assumes a 64-byte type-0 header and six base address registers.
package cfg_pkg;
    localparam int HDR_BYTES = 64;
    localparam int OFF_W     = $clog2(HDR_BYTES);
    localparam int NUM_BARS  = 6;
    localparam int BAR_IDX_W = $clog2(NUM_BARS);
    localparam int DATA_W    = 32;

    localparam logic [OFF_W-1:0] OFF_CMD     = 6'h04;
    localparam logic [OFF_W-1:0] OFF_STAT    = 6'h06;
    localparam logic [OFF_W-1:0] OFF_CLS     = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_BAR0    = 6'h10;
    localparam logic [OFF_W-1:0] OFF_BAR_END = OFF_BAR0 + OFF_W'(4 * NUM_BARS);
    localparam logic [OFF_W-1:0] OFF_ROM     = 6'h30;
    localparam logic [OFF_W-1:0] OFF_INTL    = 6'h3C;

    localparam logic [DATA_W-1:0] ROM_SENTINEL = 32'hFFFF_FFFE;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_CMD, TGT_STAT, TGT_CLS_B, TGT_CLS_H, TGT_INTL, TGT_BAR, TGT_ROM
    } wr_tgt_e;

    typedef struct packed {
        logic                 err;
        wr_tgt_e              tgt;
        logic [BAR_IDX_W-1:0] bar;
    } acc_dec_t;
endpackage

// File: rtl/cfg_access_check.sv
// Classifies one access: decides whether the offset and size pairing is
// legal and, for a legal write, which storage it targets.
// Assumes acc_size is a byte count; purely combinational.
module cfg_access_check
    import cfg_pkg::*;
(
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [2:0]       acc_size,
    output acc_dec_t         dec_o
);
    logic [OFF_W-1:0] bar_rel;
    logic             in_bar_win;

    assign bar_rel    = acc_off - OFF_BAR0;
    assign in_bar_win = (acc_off >= OFF_BAR0) && (acc_off < OFF_BAR_END) && (acc_off[1:0] == 2'b00);

    // Legality and target selection for the current access.
    always_comb begin
        dec_o.err = 1'b0;
        dec_o.tgt = TGT_NONE;
        dec_o.bar = bar_rel[2 +: BAR_IDX_W];
        if (acc_en && !acc_wr) begin
            dec_o.err = !(acc_size == 3'd1 || acc_size == 3'd2 || acc_size == 3'd4);
        end else if (acc_en && acc_wr) begin
            unique case (acc_size)
                3'd1: begin
                    if (acc_off == OFF_CLS)       dec_o.tgt = TGT_CLS_B;
                    else if (acc_off == OFF_INTL) dec_o.tgt = TGT_INTL;
                    else                          dec_o.err = 1'b1;
                end
                3'd2: begin
                    if (acc_off == OFF_CMD)       dec_o.tgt = TGT_CMD;
                    else if (acc_off == OFF_STAT) dec_o.tgt = TGT_STAT;
                    else if (acc_off == OFF_CLS)  dec_o.tgt = TGT_CLS_H;
                    else                          dec_o.err = 1'b1;
                end
                3'd4: begin
                    if (in_bar_win)               dec_o.tgt = TGT_BAR;
                    else if (acc_off == OFF_ROM)  dec_o.tgt = TGT_ROM;
                    else if (acc_off == OFF_CMD)  dec_o.tgt = TGT_CMD;
                    else                          dec_o.err = 1'b1;
                end
                default: dec_o.err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/cfg_bar_slot.sv
// One base address register. The window size is a parameter, so the
// probe mask is a constant. The read-only low bits follow the type bit
// in BAR_INIT: bits 1:0 for I/O, bits 3:0 for memory.
// Assumes BAR_SIZE is a power of two (>=4 for I/O, >=16 for memory) or 0 for unused.
module cfg_bar_slot #(
    parameter logic [31:0] BAR_SIZE = 32'h10,
    parameter logic [31:0] BAR_INIT = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] value_o
);
    localparam bit          IMPL      = (BAR_SIZE != 32'd0);
    localparam logic [31:0] RO_MASK   = BAR_INIT[0] ? 32'h3 : 32'hF;
    localparam logic [31:0] SIZE_MASK = ~(BAR_SIZE - 32'd1);
    localparam logic [31:0] RST_VAL   = IMPL ? BAR_INIT : 32'd0;

    logic [31:0] value_q;
    logic [31:0] keep_bits;
    logic [31:0] nxt;

    // Next value: the probe mask for all ones, else the data; both keep the type bits.
    always_comb begin
        keep_bits = value_q & RO_MASK;
        if (wdata == 32'hFFFF_FFFF) nxt = SIZE_MASK | keep_bits;
        else                        nxt = (wdata & ~RO_MASK) | keep_bits;
    end

    // Register update; an unused slot stays at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              value_q <= RST_VAL;
        else if (wr_en && IMPL)  value_q <= nxt;
    end

    assign value_o = value_q;

    // R8: the read-only type bits never change after reset.
    a_r8_type_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(value_q & RO_MASK));

    // R7: a probe write yields the size mask with the type bits kept.
    a_r7_probe_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && IMPL && wdata == 32'hFFFF_FFFF) |=>
        value_q == (SIZE_MASK | ($past(value_q) & RO_MASK)));
endmodule

// File: rtl/cfg_header_regs.sv
// Type-0 configuration header of one function. Identity bytes come from
// parameters; the control fields and base registers are writable under the
// size and offset rules in cfg_access_check. Read data and the error flag
// are combinational in the access cycle; writes land at the next edge.
module cfg_header_regs
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h0001,
    parameter logic [15:0] DEVICE_ID     = 16'h0002,
    parameter logic [7:0]  REVISION      = 8'h00,
    parameter logic [7:0]  PROG_IF       = 8'h00,
    parameter logic [7:0]  SUBCLASS      = 8'h00,
    parameter logic [7:0]  CLASS_CODE    = 8'h00,
    parameter logic [7:0]  HEADER_TYPE   = 8'h00,
    parameter logic [7:0]  INT_PIN       = 8'h01,
    parameter logic [7:0]  INT_LINE_INIT = 8'h00,
    parameter logic [7:0]  CLS_INIT      = 8'h00,
    parameter logic [7:0]  LAT_INIT      = 8'h00,
    parameter logic [15:0] SUBSYS_VENDOR = 16'h0000,
    parameter logic [15:0] SUBSYS_ID     = 16'h0000,
    parameter logic [7:0]  MIN_GNT       = 8'h00,
    parameter logic [7:0]  MAX_LAT       = 8'h00,
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZES = '{default: 32'h10},
    parameter logic [NUM_BARS-1:0][31:0] BAR_INITS = '{default: 32'h0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [2:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_err
);
    localparam int IDX_W = OFF_W + 1;

    acc_dec_t dec;
    logic [15:0] cmd_q, stat_q;
    logic [7:0]  cls_q, lat_q, intl_q;
    logic [31:0] rom_q;
    logic [NUM_BARS-1:0][31:0] bar_val;
    logic [7:0]  img [HDR_BYTES];
    logic        rd_size_ok;
    logic [IDX_W-1:0] idx;

    cfg_access_check u_chk (
        .acc_en  (acc_en),
        .acc_wr  (acc_wr),
        .acc_off (acc_off),
        .acc_size(acc_size),
        .dec_o   (dec)
    );

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        cfg_bar_slot #(.BAR_SIZE(BAR_SIZES[g]), .BAR_INIT(BAR_INITS[g])) u_bar (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (dec.tgt == TGT_BAR && dec.bar == BAR_IDX_W'(g)),
            .wdata  (acc_wdata),
            .value_o(bar_val[g])
        );
    end

    // Writable control fields other than the base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            stat_q <= '0;
            cls_q  <= CLS_INIT;
            lat_q  <= LAT_INIT;
            intl_q <= INT_LINE_INIT;
            rom_q  <= '0;
        end else begin
            unique case (dec.tgt)
                TGT_CMD:   cmd_q  <= acc_wdata[15:0];
                TGT_STAT:  stat_q <= acc_wdata[15:0];
                TGT_CLS_B: cls_q  <= acc_wdata[7:0];
                TGT_CLS_H: begin
                    cls_q <= acc_wdata[7:0];
                    lat_q <= acc_wdata[15:8];
                end
                TGT_INTL:  intl_q <= acc_wdata[7:0];
                TGT_ROM:   rom_q  <= (acc_wdata == ROM_SENTINEL) ? 32'hFFFF_FFFF : acc_wdata;
                default: ;
            endcase
        end
    end

    // Byte image of the whole header, little-endian per field.
    always_comb begin
        for (int i = 0; i < HDR_BYTES; i++) img[i] = 8'h00;
        img[0]  = VENDOR_ID[7:0];   img[1]  = VENDOR_ID[15:8];
        img[2]  = DEVICE_ID[7:0];   img[3]  = DEVICE_ID[15:8];
        img[4]  = cmd_q[7:0];       img[5]  = cmd_q[15:8];
        img[6]  = stat_q[7:0];      img[7]  = stat_q[15:8];
        img[8]  = REVISION;         img[9]  = PROG_IF;
        img[10] = SUBCLASS;         img[11] = CLASS_CODE;
        img[12] = cls_q;            img[13] = lat_q;
        img[14] = HEADER_TYPE;
        for (int b = 0; b < NUM_BARS; b++)
            for (int k = 0; k < 4; k++)
                img[16 + 4*b + k] = bar_val[b][8*k +: 8];
        img[44] = SUBSYS_VENDOR[7:0]; img[45] = SUBSYS_VENDOR[15:8];
        img[46] = SUBSYS_ID[7:0];     img[47] = SUBSYS_ID[15:8];
        for (int k = 0; k < 4; k++) img[48 + k] = rom_q[8*k +: 8];
        img[60] = intl_q;           img[61] = INT_PIN;
        img[62] = MIN_GNT;          img[63] = MAX_LAT;
    end

    // Read mux: up to four bytes from the offset, zero past the size or the header end.
    always_comb begin
        acc_rdata  = '0;
        idx        = '0;
        rd_size_ok = (acc_size == 3'd1 || acc_size == 3'd2 || acc_size == 3'd4);
        for (int k = 0; k < 4; k++) begin
            idx = {1'b0, acc_off} + IDX_W'(k);
            if (rd_size_ok && 3'(k) < acc_size && idx < IDX_W'(HDR_BYTES))
                acc_rdata[8*k +: 8] = img[idx[OFF_W-1:0]];
        end
    end

    assign acc_err = dec.err;

    logic [16*2+8*3+32+32*NUM_BARS-1:0] state_vec;
    assign state_vec = {cmd_q, stat_q, cls_q, lat_q, intl_q, rom_q, bar_val};

    // R11: a rejected access leaves every stored byte alone.
    a_r11_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_err) |=> $stable(state_vec));

    // R11: no error without an access.
    a_r11_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> !acc_err);

    // R2: an illegal read size flags an error and returns zero.
    a_r2_bad_read_size: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && !(acc_size == 3'd1 || acc_size == 3'd2 || acc_size == 3'd4))
        |-> (acc_err && acc_rdata == '0));

    // R9: the ROM sentinel value is stored as all ones.
    a_r9_rom_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && !acc_err && acc_size == 3'd4 && acc_off == OFF_ROM
         && acc_wdata == ROM_SENTINEL) |=> rom_q == 32'hFFFF_FFFF);

    // R6: a word write to the command offset leaves status alone.
    a_r6_cmd_word_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_size == 3'd4 && acc_off == OFF_CMD) |=> $stable(stat_q));
endmodule

// File: tb/tb_cfg_header_regs.sv
`timescale 1ns/1ps
module tb_cfg_header_regs;
    localparam logic [15:0] P_VEN = 16'hA5C3, P_DEV = 16'h1F2E;
    localparam logic [7:0]  P_REV = 8'h07, P_PIF = 8'h11, P_SUB = 8'h80, P_CLS_CODE = 8'h02;
    localparam logic [7:0]  P_HDR = 8'h00, P_IPIN = 8'h01, P_ILINE = 8'hFF, P_CLS = 8'h00, P_LAT = 8'h40;
    localparam logic [15:0] P_SSV = 16'h5A5A, P_SSID = 16'hC0DE;
    localparam logic [7:0]  P_MING = 8'h0A, P_MAXL = 8'h1B;
    localparam logic [5:0][31:0] P_SIZES = {32'h0010_0000, 32'h4, 32'h10, 32'h0, 32'h100, 32'h1000};
    localparam logic [5:0][31:0] P_INITS = {32'h0, 32'h1, 32'h4, 32'h0, 32'h1, 32'h8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_en = 1'b0, acc_wr = 1'b0;
    logic [5:0] acc_off = '0;
    logic [2:0] acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic acc_err;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] m [64];

    always #2.5 clk = ~clk;

    cfg_header_regs #(
        .VENDOR_ID(P_VEN), .DEVICE_ID(P_DEV), .REVISION(P_REV), .PROG_IF(P_PIF),
        .SUBCLASS(P_SUB), .CLASS_CODE(P_CLS_CODE), .HEADER_TYPE(P_HDR), .INT_PIN(P_IPIN),
        .INT_LINE_INIT(P_ILINE), .CLS_INIT(P_CLS), .LAT_INIT(P_LAT), .SUBSYS_VENDOR(P_SSV),
        .SUBSYS_ID(P_SSID), .MIN_GNT(P_MING), .MAX_LAT(P_MAXL),
        .BAR_SIZES(P_SIZES), .BAR_INITS(P_INITS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_off(acc_off),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err)
    );

    function automatic logic [31:0] get32(int off);
        return {m[off+3], m[off+2], m[off+1], m[off]};
    endfunction

    function automatic void put32(int off, logic [31:0] v);
        for (int k = 0; k < 4; k++) m[off+k] = v[8*k +: 8];
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 64; i++) m[i] = 8'h00;
        m[0] = P_VEN[7:0]; m[1] = P_VEN[15:8]; m[2] = P_DEV[7:0]; m[3] = P_DEV[15:8];
        m[8] = P_REV; m[9] = P_PIF; m[10] = P_SUB; m[11] = P_CLS_CODE;
        m[12] = P_CLS; m[13] = P_LAT; m[14] = P_HDR;
        for (int b = 0; b < 6; b++) put32(16 + 4*b, (P_SIZES[b] == 0) ? 32'h0 : P_INITS[b]);
        m[44] = P_SSV[7:0]; m[45] = P_SSV[15:8]; m[46] = P_SSID[7:0]; m[47] = P_SSID[15:8];
        m[60] = P_ILINE; m[61] = P_IPIN; m[62] = P_MING; m[63] = P_MAXL;
    endfunction

    function automatic void model_read(int off, int sz, output logic [31:0] d, output bit e);
        d = '0;
        e = !(sz == 1 || sz == 2 || sz == 4);
        if (!e)
            for (int k = 0; k < sz; k++)
                if (off + k < 64) d[8*k +: 8] = m[off+k];
    endfunction

    // Returns the expected error; applies the write only when commit is set.
    function automatic bit model_write(int off, int sz, logic [31:0] d, bit commit);
        bit e = 0;
        if (sz == 1) begin
            if (off == 12 || off == 60) begin
                if (commit) m[off] = d[7:0];
            end else e = 1;
        end else if (sz == 2) begin
            if (off == 4 || off == 6 || off == 12) begin
                if (commit) begin m[off] = d[7:0]; m[off+1] = d[15:8]; end
            end else e = 1;
        end else if (sz == 4) begin
            if (off >= 16 && off <= 36 && off % 4 == 0) begin
                int b = (off - 16) / 4;
                if (commit && P_SIZES[b] != 0) begin
                    logic [31:0] cur = get32(off);
                    logic [31:0] ro = cur[0] ? 32'h3 : 32'hF;
                    if (d == 32'hFFFF_FFFF) put32(off, ~(P_SIZES[b] - 1) | (cur & ro));
                    else                    put32(off, (d & ~ro) | (cur & ro));
                end
            end else if (off == 48) begin
                if (commit) put32(48, (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d);
            end else if (off == 4) begin
                if (commit) begin m[4] = d[7:0]; m[5] = d[15:8]; end
            end else e = 1;
        end else e = 1;
        return e;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One access, compared against the model in its own cycle.
    task automatic access(bit wr, int off, int sz, logic [31:0] d, string tag);
        logic [31:0] exp_d;
        bit exp_e;
        bit dummy;
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_off = 6'(off); acc_size = 3'(sz); acc_wdata = d;
        #1;
        if (wr) exp_e = model_write(off, sz, d, 1'b0);
        else    model_read(off, sz, exp_d, exp_e);
        check(acc_err === exp_e, {tag, " err"}, {31'd0, acc_err}, {31'd0, exp_e});
        if (!wr) check(acc_rdata === exp_d, {tag, " rdata"}, acc_rdata, exp_d);
        @(posedge clk);
        if (wr) dummy = model_write(off, sz, d, 1'b1);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
        #1;
        check(acc_err === 1'b0, tag, {31'd0, acc_err}, 32'd0);
    endtask

    task automatic dump(string tag);
        for (int o = 0; o < 64; o += 4) access(1'b0, o, 4, 32'h0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%08h expected=%08h", 32'd1, 32'd0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset image and assorted read widths
        dump("R1 reset image");
        access(0, 8'h0B, 1, 0, "R1 class byte");
        access(0, 8'h3D, 1, 0, "R1 int pin byte");
        access(0, 8'h02, 2, 0, "R1 device half");
        access(0, 8'h2E, 2, 0, "R1 subsystem half");
        access(0, 8'h0D, 2, 0, "R1 unaligned half");
        access(0, 8'h3E, 4, 0, "R1 read past end");
        access(0, 8'h01, 4, 0, "R1 unaligned word");
        // R2: illegal read sizes
        for (int s = 0; s < 8; s++)
            if (s != 1 && s != 2 && s != 4) access(0, 8'h00, s, 0, "R2 bad read size");
        // R3: byte writes
        access(1, 8'h0C, 1, 32'h20, "R3 cls byte");
        access(1, 8'h3C, 1, 32'h0B, "R3 int line byte");
        access(1, 8'h00, 1, 32'h55, "R3 vendor byte rejected");
        idle("R11 err pulse ends");
        access(1, 8'h0D, 1, 32'h55, "R3 latency byte rejected");
        access(1, 8'h3D, 1, 32'h55, "R3 int pin byte rejected");
        access(0, 8'h0C, 4, 0, "R3 readback");
        access(0, 8'h3C, 4, 0, "R3 readback tail");
        // R4: half writes
        access(1, 8'h04, 2, 32'hFFFF_0146, "R4 command half");
        access(1, 8'h06, 2, 32'h0000_0210, "R4 status half");
        access(1, 8'h0C, 2, 32'h0000_5520, "R4 cls+latency half");
        access(1, 8'h00, 2, 32'h1234, "R4 vendor half rejected");
        access(1, 8'h3C, 2, 32'h1234, "R4 int half rejected");
        access(1, 8'h10, 2, 32'h1234, "R4 bar half rejected");
        access(0, 8'h04, 4, 0, "R4 readback cmd/status");
        access(0, 8'h0C, 4, 0, "R4 readback cls/lat");
        // R5: illegal write sizes
        access(1, 8'h04, 3, 32'hFFFF_FFFF, "R5 size 3 write");
        access(1, 8'h04, 0, 32'hFFFF_FFFF, "R5 size 0 write");
        access(1, 8'h30, 6, 32'hFFFF_FFFF, "R5 size 6 write");
        access(0, 8'h04, 4, 0, "R5 readback");
        // R6: word writes
        access(1, 8'h04, 4, 32'hDEAD_0007, "R6 command word");
        access(0, 8'h04, 4, 0, "R6 status kept");
        access(1, 8'h08, 4, 32'h1, "R6 class word rejected");
        access(1, 8'h28, 4, 32'h1, "R6 cis word rejected");
        access(1, 8'h3C, 4, 32'h1, "R6 int word rejected");
        access(1, 8'h12, 4, 32'h1, "R6 unaligned bar rejected");
        // R7: size probes on every base register
        for (int b = 0; b < 6; b++) access(1, 16 + 4*b, 4, 32'hFFFF_FFFF, "R7 probe");
        dump("R7 probe readback");
        // R8: ordinary writes keep type bits
        access(1, 8'h10, 4, 32'h1234_5677, "R8 memory write");
        access(1, 8'h14, 4, 32'hABCD_EF02, "R8 io write");
        access(1, 8'h1C, 4, 32'h0000_0003, "R8 memory typed write");
        access(1, 8'h20, 4, 32'h0000_0000, "R8 io clear");
        dump("R8 readback");
        // R10: unused slot
        access(1, 8'h18, 4, 32'hFFFF_FFFF, "R10 unused probe");
        access(1, 8'h18, 4, 32'h0000_1234, "R10 unused write");
        access(0, 8'h18, 4, 0, "R10 unused reads zero");
        // R9: ROM base sentinel
        access(1, 8'h30, 4, 32'hFFFF_FFFE, "R9 sentinel");
        access(0, 8'h30, 4, 0, "R9 sentinel readback");
        access(1, 8'h30, 4, 32'h000C_0001, "R9 plain value");
        access(0, 8'h30, 4, 0, "R9 plain readback");
        access(1, 8'h30, 4, 32'hFFFF_FFFF, "R9 all ones");
        access(0, 8'h30, 4, 0, "R9 all ones readback");
        // R11: whole image unchanged by rejected traffic
        idle("R11 idle");
        dump("R11 final image");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule